// File: doc/BRIEF.md
# Reorder Buffer with Precise Translation Exceptions

This block keeps the instructions of an in-order-issue, out-of-order-complete pipeline in program order. Decode claims one slot per instruction at the tail of a circular buffer and receives the slot number as a tag. Writeback later fills in the result under that tag. The oldest slot retires to the register file once its result is present. Results may arrive in any order, but the register file is only ever updated in program order.

A slot can carry a translation fault from one of two sources. A fault from fetch-side translation is noted when the slot is claimed, and such a slot needs no writeback. A fault from data-side translation arrives with the writeback, together with the virtual address that failed. A fault does nothing until its slot becomes the oldest. At that point the block discards every slot, raises a one-cycle flush that resets the rest of the pipeline (register file included), and sends fetch to a fixed handler address. It also latches the faulting PC, the faulting address and a one-bit cause into registers that stay readable afterwards. Straight after reset the block sends fetch to a fixed boot address.

Top module: `rob_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `redirect_valid` is 1 and `redirect_pc` is 0x0000_1000.
- R2: At most one slot retires per cycle, always the oldest, and only when its result is present and it carries no fault. `commit_rd` and `commit_data` come from that slot, and `commit_we` equals the write flag given at allocation.
- R3: With DEPTH slots occupied, `alloc_ready` is 0. A request made while `alloc_ready` is 0 claims no slot, so the next tag handed out is unchanged.
- R4: A slot claimed with `alloc_xfault`=1 needs no writeback. When it becomes the oldest, the exception is taken with `exc_cause`=0 and `exc_addr` equal to the slot's PC.
- R5: A writeback with `wb_xfault`=1 marks its slot faulting. When it becomes the oldest, the exception is taken with `exc_cause`=1 and `exc_addr` equal to `wb_addr`.
- R6: A fault takes effect only at the oldest slot, so every older slot retires first. In the cycle it takes effect, `flush`=1, `redirect_valid`=1, `redirect_pc`=0x0000_2000, `commit_valid`=0 and `alloc_ready`=0.
- R7: From the cycle after a flush, `exc_pc` holds the faulting slot's PC. It changes only at a later flush.
- R8: A flush discards all slots. Younger slots never retire, writebacks to their old tags have no effect, and the next allocation receives tag 0.
- R9: After reset `alloc_ready`=1, `commit_valid`=0, `flush`=0, and `exc_pc`, `exc_addr` and `exc_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Decode requests a slot |
| alloc_pc | input | 32 | PC of the instruction being allocated |
| alloc_rd | input | 5 | Destination register index |
| alloc_we | input | 1 | Instruction writes the register file |
| alloc_xfault | input | 1 | Fetch-side translation fault |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | log2(DEPTH) | Tag of the slot claimed this cycle |
| wb_valid | input | 1 | Writeback present |
| wb_tag | input | log2(DEPTH) | Slot being written back |
| wb_data | input | 32 | Result value |
| wb_xfault | input | 1 | Data-side translation fault |
| wb_addr | input | 32 | Faulting virtual address |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_rd | output | 5 | Retiring destination register |
| commit_data | output | 32 | Retiring result |
| commit_we | output | 1 | Register file write enable |
| flush | output | 1 | Pipeline-wide reset pulse |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Boot or handler address |
| exc_pc | output | 32 | PC of the last faulting instruction |
| exc_addr | output | 32 | Address of the last fault |
| exc_cause | output | 1 | 0 fetch-side, 1 data-side |

## Verification
The bench builds the block with DEPTH=4. With only four slots, the full condition, a refused request and pointer wrap-around all occur within a few dozen cycles. The same small depth lets one short sequence place a faulting slot behind an older slot and in front of a younger one. Both fault sources are exercised that way, along with writebacks that arrive out of order.

// File: rtl/rob_pkg.sv
// Package: shared types for the reorder buffer.
// Assumes a 32-bit datapath and 32 architectural registers.
package rob_pkg;
    localparam int XLEN  = 32;
    localparam int REG_W = 5;

    localparam logic [XLEN-1:0] BOOT_PC    = 32'h0000_1000;
    localparam logic [XLEN-1:0] HANDLER_PC = 32'h0000_2000;

    typedef enum logic {
        EXC_FETCH_XLATE = 1'b0,
        EXC_DATA_XLATE  = 1'b1
    } exc_cause_e;

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             fault;
        exc_cause_e       cause;
        logic             we;
        logic [REG_W-1:0] rd;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  data;
        logic [XLEN-1:0]  addr;
    } rob_slot_t;
endpackage

// File: rtl/rob_ptrs.sv
// Module: head/tail pointers of the circular buffer.
// Each pointer carries one wrap bit above the index so that full and empty
// can be told apart. Assumes DEPTH is a power of two, push is never asserted
// when full, and pop is never asserted when empty.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full,
    output logic             empty
);
    logic [IDX_W:0] head_q, tail_q;

    // Advance the pointers; a clear returns both to slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    // Derive the indices and the occupancy flags.
    always_comb begin
        head_idx = head_q[IDX_W-1:0];
        tail_idx = tail_q[IDX_W-1:0];
        empty    = (head_q == tail_q);
        full     = (head_q[IDX_W] != tail_q[IDX_W]) &&
                   (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
    end
endmodule

// File: rtl/rob_store.sv
// Module: slot storage, one register per slot built by a generate loop.
// Allocation writes a whole slot. A writeback fills the result, or a data
// fault, only into a live slot that is still waiting. Retirement and clear
// release slots. Assumes allocation and retirement never name the same slot.
module rob_store #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      alloc_en,
    input  logic [IDX_W-1:0]          alloc_idx,
    input  rob_pkg::rob_slot_t        alloc_slot,
    input  logic                      wb_en,
    input  logic [IDX_W-1:0]          wb_idx,
    input  logic [rob_pkg::XLEN-1:0]  wb_data,
    input  logic                      wb_xfault,
    input  logic [rob_pkg::XLEN-1:0]  wb_addr,
    input  logic                      retire_en,
    input  logic [IDX_W-1:0]          retire_idx,
    input  logic [IDX_W-1:0]          rd_idx,
    output rob_pkg::rob_slot_t        rd_slot
);
    import rob_pkg::*;

    rob_slot_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_slot_t slot_q;

        // Update one slot: allocate, take a writeback, or release.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                slot_q <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                slot_q <= alloc_slot;
            end else begin
                if (wb_en && wb_idx == IDX_W'(i) && slot_q.valid && !slot_q.done) begin
                    slot_q.done <= 1'b1;
                    slot_q.data <= wb_data;
                    if (wb_xfault) begin
                        slot_q.fault <= 1'b1;
                        slot_q.cause <= EXC_DATA_XLATE;
                        slot_q.addr  <= wb_addr;
                    end
                end
                if (retire_en && retire_idx == IDX_W'(i)) slot_q.valid <= 1'b0;
            end
        end

        assign slots[i] = slot_q;
    end

    assign rd_slot = slots[rd_idx];
endmodule

// File: rtl/rob_exc.sv
// Module: fetch redirect and exception capture registers.
// Requests the boot address during reset and for one cycle after it. On a
// taken exception it requests the handler address and latches PC, address
// and cause, which hold until the next exception.
module rob_exc (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  rob_pkg::rob_slot_t        head_slot,
    output logic                      redirect_valid,
    output logic [rob_pkg::XLEN-1:0]  redirect_pc,
    output logic [rob_pkg::XLEN-1:0]  exc_pc,
    output logic [rob_pkg::XLEN-1:0]  exc_addr,
    output logic                      exc_cause
);
    import rob_pkg::*;

    logic boot_pend_q;

    // Keep the boot request alive until the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_pend_q <= 1'b1;
        else        boot_pend_q <= 1'b0;
    end

    // Latch the faulting slot's information when the exception is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_pc    <= '0;
            exc_addr  <= '0;
            exc_cause <= 1'b0;
        end else if (take) begin
            exc_pc    <= head_slot.pc;
            exc_addr  <= head_slot.addr;
            exc_cause <= head_slot.cause;
        end
    end

    // Choose the fetch restart address.
    always_comb begin
        redirect_valid = boot_pend_q || take;
        redirect_pc    = take ? HANDLER_PC : BOOT_PC;
    end
endmodule

// File: rtl/rob_core.sv
// Module: reorder buffer top. Claims slots at decode, accepts results and
// data faults at writeback, retires the oldest finished slot, and turns a
// faulting oldest slot into a flush plus a redirect to the handler.
// Assumes DEPTH is a power of two, at least 2.
module rob_core #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [rob_pkg::XLEN-1:0]  alloc_pc,
    input  logic [rob_pkg::REG_W-1:0] alloc_rd,
    input  logic                      alloc_we,
    input  logic                      alloc_xfault,
    output logic                      alloc_ready,
    output logic [IDX_W-1:0]          alloc_tag,
    input  logic                      wb_valid,
    input  logic [IDX_W-1:0]          wb_tag,
    input  logic [rob_pkg::XLEN-1:0]  wb_data,
    input  logic                      wb_xfault,
    input  logic [rob_pkg::XLEN-1:0]  wb_addr,
    output logic                      commit_valid,
    output logic [rob_pkg::REG_W-1:0] commit_rd,
    output logic [rob_pkg::XLEN-1:0]  commit_data,
    output logic                      commit_we,
    output logic                      flush,
    output logic                      redirect_valid,
    output logic [rob_pkg::XLEN-1:0]  redirect_pc,
    output logic [rob_pkg::XLEN-1:0]  exc_pc,
    output logic [rob_pkg::XLEN-1:0]  exc_addr,
    output logic                      exc_cause
);
    import rob_pkg::*;

    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full, empty, push, retire, take_exc;
    rob_slot_t        head_slot, new_slot;

    // Decide retirement, exception and allocation for this cycle.
    always_comb begin
        take_exc    = !empty && head_slot.valid && head_slot.done && head_slot.fault;
        retire      = !empty && head_slot.valid && head_slot.done && !head_slot.fault;
        alloc_ready = !full && !take_exc;
        push        = alloc_valid && alloc_ready;
        alloc_tag   = tail_idx;
    end

    // Build the slot written at allocation; a fetch fault needs no writeback.
    always_comb begin
        new_slot       = '0;
        new_slot.valid = 1'b1;
        new_slot.done  = alloc_xfault;
        new_slot.fault = alloc_xfault;
        new_slot.cause = EXC_FETCH_XLATE;
        new_slot.we    = alloc_we;
        new_slot.rd    = alloc_rd;
        new_slot.pc    = alloc_pc;
        new_slot.addr  = alloc_pc;
    end

    // Drive the register-file port and the flush.
    always_comb begin
        commit_valid = retire;
        commit_rd    = head_slot.rd;
        commit_data  = head_slot.data;
        commit_we    = retire && head_slot.we;
        flush        = take_exc;
    end

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (retire),
        .clear    (take_exc),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full),
        .empty    (empty)
    );

    rob_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (take_exc),
        .alloc_en   (push),
        .alloc_idx  (tail_idx),
        .alloc_slot (new_slot),
        .wb_en      (wb_valid),
        .wb_idx     (wb_tag),
        .wb_data    (wb_data),
        .wb_xfault  (wb_xfault),
        .wb_addr    (wb_addr),
        .retire_en  (retire),
        .retire_idx (head_idx),
        .rd_idx     (head_idx),
        .rd_slot    (head_slot)
    );

    rob_exc u_exc (
        .clk            (clk),
        .rst_n          (rst_n),
        .take           (take_exc),
        .head_slot      (head_slot),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .exc_pc         (exc_pc),
        .exc_addr       (exc_addr),
        .exc_cause      (exc_cause)
    );
endmodule

// File: rtl/rob_chk.sv
// Module: protocol checker for rob_core, attached with bind. Keeps its own
// occupancy count from the port handshakes and checks the port rules.
module rob_chk #(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        alloc_valid,
    input logic        alloc_ready,
    input logic        commit_valid,
    input logic        flush,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic [31:0] exc_pc
);
    localparam int CNT_W = $clog2(DEPTH) + 2;
    logic [CNT_W-1:0] occ_q;

    // Track occupancy as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) occ_q <= '0;
        else occ_q <= occ_q + CNT_W'(alloc_valid && alloc_ready) - CNT_W'(commit_valid);
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == CNT_W'(DEPTH)) |-> !alloc_ready);
    // R2
    empty_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (!commit_valid && !flush));
    // R6
    flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (redirect_valid && redirect_pc == 32'h0000_2000 && !commit_valid && !alloc_ready));
    // R8
    post_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!commit_valid && !flush));
    // R7
    exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> $stable(exc_pc));
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_rob_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .commit_valid   (commit_valid),
    .flush          (flush),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .exc_pc         (exc_pc)
);

// File: tb/tb_rob_core.sv
// Bench: scoreboard of expected retirements, checked by a monitor at negedge.
module tb_rob_core;
    localparam int DEPTH = 4;
    localparam int IDX_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_we = 0, alloc_xfault = 0;
    logic [31:0] alloc_pc = '0;
    logic [4:0]  alloc_rd = '0;
    logic alloc_ready;
    logic [IDX_W-1:0] alloc_tag;
    logic wb_valid = 0, wb_xfault = 0;
    logic [IDX_W-1:0] wb_tag = '0;
    logic [31:0] wb_data = '0, wb_addr = '0;
    logic commit_valid, commit_we, flush, redirect_valid, exc_cause;
    logic [4:0]  commit_rd;
    logic [31:0] commit_data, redirect_pc, exc_pc, exc_addr;

    rob_core #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_rd(alloc_rd),
        .alloc_we(alloc_we), .alloc_xfault(alloc_xfault),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .wb_xfault(wb_xfault), .wb_addr(wb_addr),
        .commit_valid(commit_valid), .commit_rd(commit_rd),
        .commit_data(commit_data), .commit_we(commit_we),
        .flush(flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .exc_pc(exc_pc), .exc_addr(exc_addr), .exc_cause(exc_cause)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [4:0]  rd;
        logic        we;
        logic [31:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: every retirement must match the oldest expected item.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && commit_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected retirement rd", {27'd0, commit_rd}, 32'hffff_ffff);
            end else begin
                e = exp_q.pop_front();
                check(commit_rd == e.rd && commit_we == e.we && commit_data == e.data,
                      "R2", "retired data", commit_data, e.data);
            end
        end
    end

    task automatic do_alloc(input logic [31:0] pc, input logic [4:0] rd, input logic we,
                            input logic xf, output logic [IDX_W-1:0] tag);
        @(posedge clk); #1;
        alloc_valid = 1; alloc_pc = pc; alloc_rd = rd; alloc_we = we; alloc_xfault = xf;
        tag = alloc_tag;
        @(posedge clk); #1;
        alloc_valid = 0; alloc_xfault = 0;
    endtask

    task automatic do_wb(input logic [IDX_W-1:0] tag, input logic [31:0] d,
                         input logic xf, input logic [31:0] a);
        @(posedge clk); #1;
        wb_valid = 1; wb_tag = tag; wb_data = d; wb_xfault = xf; wb_addr = a;
        @(posedge clk); #1;
        wb_valid = 0; wb_xfault = 0;
    endtask

    task automatic push_exp(input logic [4:0] rd, input logic we, input logic [31:0] d);
        exp_q.push_back({rd, we, d});
    endtask

    // Wait for a flush, then check the flush cycle and the latched state.
    task automatic expect_exc(input string req, input logic [31:0] pc,
                              input logic [31:0] addr, input logic cause);
        bit seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (flush) begin seen = 1; break; end
        end
        check(seen, "R6", "flush seen", {31'd0, seen}, 32'd1);
        check(redirect_valid && redirect_pc == 32'h0000_2000, "R6", "handler redirect",
              redirect_pc, 32'h0000_2000);
        check(!commit_valid && !alloc_ready, "R6", "no retire/alloc at flush",
              {30'd0, commit_valid, alloc_ready}, 32'd0);
        @(negedge clk);
        check(exc_pc == pc, "R7", "exc_pc", exc_pc, pc);
        check(exc_addr == addr, req, "exc_addr", exc_addr, addr);
        check(exc_cause == cause, req, "exc_cause", {31'd0, exc_cause}, {31'd0, cause});
        check(!flush && alloc_ready, "R8", "flush is one cycle", {31'd0, flush}, 32'd0);
    endtask

    initial begin
        logic [IDX_W-1:0] ta, tb, tc, td, start;
        logic [IDX_W-1:0] t4 [4];

        // R1/R9: reset behaviour
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(redirect_valid && redirect_pc == 32'h0000_1000, "R1", "boot redirect in reset",
              redirect_pc, 32'h0000_1000);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        check(redirect_valid && redirect_pc == 32'h0000_1000, "R1", "boot redirect after reset",
              redirect_pc, 32'h0000_1000);
        check(alloc_ready && !commit_valid && !flush, "R9", "reset handshakes",
              {29'd0, alloc_ready, commit_valid, flush}, 32'd4);
        check(exc_pc == 0 && exc_addr == 0 && exc_cause == 0, "R9", "reset exc regs", exc_pc, 0);
        @(negedge clk);
        check(!redirect_valid, "R1", "boot redirect ends", {31'd0, redirect_valid}, 32'd0);

        // R2: out-of-order results, in-order retirement, one non-writing slot
        push_exp(5'd1, 1'b1, 32'hA1);
        push_exp(5'd2, 1'b0, 32'hB2);
        push_exp(5'd3, 1'b1, 32'hC3);
        do_alloc(32'h100, 5'd1, 1'b1, 1'b0, ta);
        do_alloc(32'h104, 5'd2, 1'b0, 1'b0, tb);
        do_alloc(32'h108, 5'd3, 1'b1, 1'b0, tc);
        do_wb(tc, 32'hC3, 1'b0, 32'h0);
        do_wb(ta, 32'hA1, 1'b0, 32'h0);
        do_wb(tb, 32'hB2, 1'b0, 32'h0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all three retired", exp_q.size(), 0);

        // R3: fill, refused request, drain, tag unchanged
        @(negedge clk);
        start = alloc_tag;
        for (int i = 0; i < 4; i++) begin
            push_exp(5'(8 + i), 1'b1, 32'h50 + i);
            do_alloc(32'h200 + 4 * i, 5'(8 + i), 1'b1, 1'b0, t4[i]);
        end
        @(negedge clk);
        check(!alloc_ready, "R3", "ready low when full", {31'd0, alloc_ready}, 32'd0);
        do_alloc(32'h300, 5'd20, 1'b1, 1'b0, td);
        for (int i = 0; i < 4; i++) do_wb(t4[i], 32'h50 + i, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3", "only four retired", exp_q.size(), 0);
        check(alloc_tag == start, "R3", "refused request claimed no slot",
              {30'd0, alloc_tag}, {30'd0, start});

        // R5/R6/R8: data fault behind an older slot, ahead of a younger one
        push_exp(5'd4, 1'b1, 32'hD0);
        do_alloc(32'h400, 5'd4, 1'b1, 1'b0, ta);
        do_alloc(32'h404, 5'd5, 1'b1, 1'b0, tb);
        do_alloc(32'h408, 5'd6, 1'b1, 1'b0, tc);
        do_wb(tc, 32'hD2, 1'b0, 32'h0);
        do_wb(tb, 32'hD1, 1'b1, 32'h0000_0040);
        do_wb(ta, 32'hD0, 1'b0, 32'h0);
        expect_exc("R5", 32'h404, 32'h0000_0040, 1'b1);
        check(exp_q.size() == 0, "R6", "older slot retired first", exp_q.size(), 0);
        do_wb(tc, 32'hEE, 1'b0, 32'h0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        check(alloc_tag == 0, "R8", "tag restarts at 0", {30'd0, alloc_tag}, 32'd0);
        push_exp(5'd7, 1'b1, 32'hF0);
        do_alloc(32'h500, 5'd7, 1'b1, 1'b0, td);
        do_wb(td, 32'hF0, 1'b0, 32'h0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R8", "new slot retires after flush", exp_q.size(), 0);

        // R4: fetch fault recorded at allocation, no writeback for it
        push_exp(5'd9, 1'b1, 32'h90);
        do_alloc(32'h600, 5'd9, 1'b1, 1'b0, ta);
        do_alloc(32'h604, 5'd10, 1'b1, 1'b1, tb);
        do_alloc(32'h608, 5'd11, 1'b1, 1'b0, tc);
        do_wb(tc, 32'h92, 1'b0, 32'h0);
        do_wb(ta, 32'h90, 1'b0, 32'h0);
        expect_exc("R4", 32'h604, 32'h604, 1'b0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4", "younger slot never retired", exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #40000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule